// File: doc/BRIEF.md
# UART Receive FIFO with Error Tally and Guarded Status Flags

This block is the receive-side store of a UART. The receiver pushes each byte together with two tags, one for a parity error and one for a framing error. The CPU pops bytes in arrival order. While the bytes sit in the queue, the block keeps a live tally of how many stored entries carry each kind of error. The tally goes up when a tagged byte enters and goes down when it leaves.

A 16-bit status word gives the CPU the two tallies in its upper byte and eight operating flags in its lower byte. Two of those flags are the error tags of the entry at the head of the queue. The other six flags latch events from hardware. Software cannot set any of the six. Software clears one by reading it as 1 and then writing 0 to that bit. A fresh hardware event that arrives between the read and the write cancels the pending clear, so the new event survives the write.

Top module: `uart_rx_err_fifo`

## Requirements
- R1: After reset the status word reads 0x0060, the popped-data output reads 0 and the queue is empty.
- R2: Bytes are returned in push order. A pop accepted at a clock edge presents its byte on `pop_data` after that same edge.
- R3: Status bits 15:12 count the stored entries tagged with a parity error, and bits 11:8 count those tagged with a framing error. A push raises these counts, a pop lowers them, and a simultaneous push and pop moves each count by the incoming tag minus the outgoing tag.
- R4: The queue holds 16 entries and the counts are 4 bits wide. When all 16 stored entries carry an error of one kind, that count reads 0.
- R5: A push into a full queue is dropped, and a push together with a pop on a full queue drops the push. A pop from an empty queue leaves `pop_data` and the counts unchanged.
- R6: CPU writes have no effect on bits 15:8 or on bits 3:2.
- R7: The clearable flags are bit 7 (receive error), bit 6 (transmit end), bit 5 (transmit queue empty), bit 4 (break), bit 1 (receive full) and bit 0 (data ready). Writing 1 to any of them changes nothing.
- R8: A clearable flag is cleared by a write of 0 only if a status read (`reg_rd`) saw that flag at 1 earlier. A write of 0 without such a read leaves the flag set.
- R9: If hardware sets a flag again after it was read as 1, the qualification from that read is cancelled, and the next write of 0 leaves the flag set.
- R10: Bit 3 shows the framing tag and bit 2 shows the parity tag of the head entry. Both read 0 when the queue is empty.
- R11: Bit 7 sets when an accepted push carries any error tag. Bit 1 sets when occupancy rises to 8. Bits 6, 5, 4 and 0 set on pulses of `tx_end_set`, `tx_empty_set`, `brk_set` and `rdy_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Receiver delivers a byte this cycle |
| push_data | input | 8 | Received byte |
| push_perr | input | 1 | Parity-error tag of the byte |
| push_ferr | input | 1 | Framing-error tag of the byte |
| pop | input | 1 | CPU takes the head byte |
| pop_data | output | 8 | Last byte popped |
| tx_end_set | input | 1 | Pulse: transmitter finished |
| tx_empty_set | input | 1 | Pulse: transmit queue drained |
| brk_set | input | 1 | Pulse: break detected |
| rdy_set | input | 1 | Pulse: receive data ready |
| reg_rd | input | 1 | CPU reads the status word this cycle |
| reg_wr | input | 1 | CPU writes the status word this cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Status word |

## Verification
The hardest case to reach is the full queue with every entry tagged, where both counts wrap to 0 even though the queue holds sixteen errored bytes. The bench pushes sixteen doubly tagged bytes, checks the counts at fifteen and again at sixteen, and then tries both a lone push and a push-with-pop on the full queue. The second hard case is a hardware event that lands between a read and the clearing write. The bench reads the break flag, pulses `brk_set`, and only then writes 0.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int RXS_DW = 8;

  // status low-byte bit positions
  localparam int B_RXERR = 7;
  localparam int B_TXEND = 6;
  localparam int B_TXEMP = 5;
  localparam int B_BRK   = 4;
  localparam int B_HFER  = 3;
  localparam int B_HPER  = 2;
  localparam int B_RFULL = 1;
  localparam int B_RDY   = 0;

  localparam logic [7:0] FLAG_CLR_MASK = 8'hF3;
  localparam logic [7:0] FLAG_RST_VAL  = 8'h60;

  typedef struct packed {
    logic [RXS_DW-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_ent_t;
endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push_valid,
  input  rx_ent_t                 push_ent,
  input  logic                    pop,
  output logic [RXS_DW-1:0]       pop_data,
  output rx_ent_t                 head_ent,
  output logic                    head_vld,
  output logic [$clog2(DEPTH):0]  level,
  output logic                    push_ok,
  output logic                    pop_ok
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = AW'(DEPTH) == '0 ? {1'b1, {AW{1'b0}}} : (AW+1)'(DEPTH);

  rx_ent_t       mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  assign full     = (level == FULL_LVL);
  assign empty    = (level == '0);
  assign push_ok  = push_valid && !full;
  assign pop_ok   = pop && !empty;
  assign head_vld = !empty;
  assign head_ent = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      pop_data <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok) begin
        rd_ptr   <= rd_ptr + 1'b1;
        pop_data <= mem[rd_ptr].data;
      end
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL); // R5
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !pop) |=> $stable(level)); // R5
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> $stable(pop_data)); // R5
endmodule

// File: rtl/rxs_err_count.sv
module rxs_err_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  // modulo-2^W step; a tally of 2^W reads back as zero
  function automatic logic [W-1:0] cnt_step(input logic [W-1:0] c,
                                            input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_step(cnt, inc, dec);
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc == dec) |=> $stable(cnt)); // R3
endmodule

// File: rtl/rxs_flags.sv
module rxs_flags #(
  parameter int          NF       = 8,
  parameter logic [NF-1:0] CLR_MASK = '1,
  parameter logic [NF-1:0] RST_VAL  = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [NF-1:0] wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] qual
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    if (CLR_MASK[i]) begin : g_clr
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          flags[i] <= RST_VAL[i];
          qual[i]  <= 1'b0;
        end else if (set_evt[i]) begin
          flags[i] <= 1'b1;
          qual[i]  <= 1'b0;
        end else if (wr_stb && !wdata[i] && qual[i]) begin
          flags[i] <= 1'b0;
          qual[i]  <= 1'b0;
        end else if (rd_stb && flags[i]) begin
          qual[i]  <= 1'b1;
        end
      end
    end else begin : g_none
      assign flags[i] = 1'b0;
      assign qual[i]  = 1'b0;
    end
  end

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(set_evt)) == '0); // R7
  AST_CLR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (~flags & $past(flags) & ~$past(qual)) == '0); // R8
  AST_REARM_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (qual & $past(set_evt)) == '0); // R9
endmodule

// File: rtl/uart_rx_err_fifo.sv
module uart_rx_err_fifo
  import rxs_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int RFULL_LVL = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_valid,
  input  logic [RXS_DW-1:0]  push_data,
  input  logic               push_perr,
  input  logic               push_ferr,
  input  logic               pop,
  output logic [RXS_DW-1:0]  pop_data,
  input  logic               tx_end_set,
  input  logic               tx_empty_set,
  input  logic               brk_set,
  input  logic               rdy_set,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] RFULL_PRE = (AW+1)'(RFULL_LVL - 1);

  rx_ent_t     push_ent, head_ent;
  logic        head_vld, push_ok, pop_ok;
  logic [AW:0] level;
  logic [1:0]        err_inc, err_dec;
  logic [1:0][AW-1:0] err_cnt;
  logic [7:0]  set_evt, flags, qual;
  logic        rfull_evt, rxerr_evt;

  assign push_ent = '{data: push_data, perr: push_perr, ferr: push_ferr};

  rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_ent(push_ent),
    .pop(pop), .pop_data(pop_data),
    .head_ent(head_ent), .head_vld(head_vld), .level(level),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  // index 1: parity tally, index 0: framing tally
  assign err_inc[1] = push_ok && push_ent.perr;
  assign err_dec[1] = pop_ok  && head_ent.perr;
  assign err_inc[0] = push_ok && push_ent.ferr;
  assign err_dec[0] = pop_ok  && head_ent.ferr;

  for (genvar k = 0; k < 2; k++) begin : g_tally
    rxs_err_count #(.W(AW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(err_inc[k]), .dec(err_dec[k]), .cnt(err_cnt[k])
    );
  end

  assign rxerr_evt = push_ok && (push_perr || push_ferr);
  assign rfull_evt = push_ok && !pop_ok && (level == RFULL_PRE);

  always_comb begin
    set_evt          = '0;
    set_evt[B_RXERR] = rxerr_evt;
    set_evt[B_TXEND] = tx_end_set;
    set_evt[B_TXEMP] = tx_empty_set;
    set_evt[B_BRK]   = brk_set;
    set_evt[B_RFULL] = rfull_evt;
    set_evt[B_RDY]   = rdy_set;
  end

  rxs_flags #(.NF(8), .CLR_MASK(FLAG_CLR_MASK), .RST_VAL(FLAG_RST_VAL)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt),
    .rd_stb(reg_rd), .wr_stb(reg_wr), .wdata(reg_wdata[7:0]),
    .flags(flags), .qual(qual)
  );

  always_comb begin
    reg_rdata         = {err_cnt[1], err_cnt[0], flags};
    reg_rdata[B_HFER] = head_vld && head_ent.ferr;
    reg_rdata[B_HPER] = head_vld && head_ent.perr;
  end

  AST_RO_TALLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !push_ok && !pop_ok) |=> $stable(reg_rdata[15:8])); // R6
  AST_HEAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> (reg_rdata[3:2] == 2'b00)); // R10
  AST_RXERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rxerr_evt |=> reg_rdata[B_RXERR]); // R11
endmodule

// File: tb/tb_uart_rx_err_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_err_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_valid = 0, push_perr = 0, push_ferr = 0, pop = 0;
  logic [7:0]  push_data = 0;
  logic [7:0]  pop_data;
  logic        tx_end_set = 0, tx_empty_set = 0, brk_set = 0, rdy_set = 0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;

  int nchk = 0, nerr = 0;
  logic [9:0] q[$];        // {data, perr, ferr}
  logic [7:0] exp_pop = 8'h00;
  bit         pend = 0;

  always #2 clk = ~clk;

  uart_rx_err_fifo dut (
    .clk(clk), .rst_n(rst_n),
    .push_valid(push_valid), .push_data(push_data),
    .push_perr(push_perr), .push_ferr(push_ferr),
    .pop(pop), .pop_data(pop_data),
    .tx_end_set(tx_end_set), .tx_empty_set(tx_empty_set),
    .brk_set(brk_set), .rdy_set(rdy_set),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard side of the popped data (R2, R5)
  always @(posedge clk) begin
    if (rst_n && pop) begin
      if (q.size() > 0) exp_pop = q.pop_front()[9:2];
      pend = 1;
    end
  end
  always @(negedge clk) begin
    if (pend) begin
      chk("R2 pop order / R5 empty hold", {8'h00, pop_data}, {8'h00, exp_pop});
      pend = 0;
    end
  end

  task automatic check_model();
    logic [3:0] pc, fc;
    logic [1:0] hd;
    pc = 0; fc = 0;
    foreach (q[i]) begin
      pc += 4'(q[i][1]);
      fc += 4'(q[i][0]);
    end
    chk("R3 R4 tallies", {8'h00, reg_rdata[15:8]}, {8'h00, pc, fc});
    hd = (q.size() > 0) ? {q[0][0], q[0][1]} : 2'b00;
    chk("R10 head tags", {14'h0, reg_rdata[3:2]}, {14'h0, hd});
  endtask

  task automatic chk_flags(string tag, logic [7:0] exp);
    chk(tag, {8'h00, reg_rdata[7:0] & 8'hF3}, {8'h00, exp});
  endtask

  // driver: pushes expected items into the scoreboard queue
  task automatic op(bit dp, logic [7:0] d, bit p, bit f, bit dpop);
    @(negedge clk);
    push_valid = dp; push_data = d; push_perr = p; push_ferr = f; pop = dpop;
    if (dp && q.size() < 16) q.push_back({d, p, f});
    @(negedge clk);
    push_valid = 0; pop = 0; push_perr = 0; push_ferr = 0;
    check_model();
  endtask

  task automatic cpu_read();
    @(negedge clk); reg_rd = 1;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic cpu_write(logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: brk_set = 1;
      1: tx_end_set = 1;
      2: tx_empty_set = 1;
      default: rdy_set = 1;
    endcase
    @(negedge clk);
    brk_set = 0; tx_end_set = 0; tx_empty_set = 0; rdy_set = 0;
  endtask

  initial begin
    #(200000 * 4);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", reg_rdata, 16'h0060);
    chk("R1 reset pop_data", {8'h00, pop_data}, 16'h0000);

    cpu_write(16'h00FF);
    chk("R7 write ones", reg_rdata, 16'h0060);
    cpu_write(16'h0000);
    chk("R8 clear without read", reg_rdata, 16'h0060);
    cpu_read();
    cpu_write(16'h0000);
    chk("R8 clear after read", reg_rdata, 16'h0000);

    op(1, 8'hA1, 1, 0, 0);
    op(1, 8'hB2, 0, 1, 0);
    op(1, 8'hC3, 1, 1, 0);
    chk("R3 R10 R11 after three pushes", reg_rdata, 16'h2284);
    cpu_write(16'hFFFF);
    chk("R6 R7 write all ones", reg_rdata, 16'h2284);
    cpu_write(16'h00F3);
    check_model();  // R6 bits 15:8 and 3:2 after a write

    op(0, 8'h00, 0, 0, 1);
    chk("R3 after pop", reg_rdata, 16'h1288);
    op(1, 8'hD4, 1, 0, 1);
    chk("R3 simultaneous push pop", reg_rdata, 16'h218C);
    op(0, 8'h00, 0, 0, 1);
    op(0, 8'h00, 0, 0, 1);
    chk("R10 empty head", reg_rdata, 16'h0080);
    op(0, 8'h00, 0, 0, 1);  // R5 pop on empty
    chk("R5 empty pop counts", reg_rdata, 16'h0080);

    for (int i = 0; i < 7; i++) op(1, 8'(8'h10 + i), 0, 0, 0);
    chk_flags("R11 seven entries no full", 8'h80);
    op(1, 8'h17, 0, 0, 0);
    chk_flags("R11 full level reached", 8'h82);

    cpu_read();
    cpu_write(16'h007D);
    chk_flags("R8 clear rx error and full", 8'h00);

    pulse(0);
    chk_flags("R11 break", 8'h10);
    cpu_read();
    pulse(0);
    cpu_write(16'h0000);
    chk_flags("R9 re-armed break survives", 8'h10);
    cpu_read();
    cpu_write(16'h0000);
    chk_flags("R8 break cleared", 8'h00);

    pulse(1); pulse(2); pulse(3);
    chk_flags("R11 tx end, tx empty, ready", 8'h61);
    cpu_read();
    cpu_write(16'h0000);
    chk_flags("R8 clear three", 8'h00);

    for (int i = 0; i < 8; i++) op(0, 8'h00, 0, 0, 1);
    chk("R3 drained", reg_rdata, 16'h0000);

    for (int i = 0; i < 15; i++) op(1, 8'(8'h40 + i), 1, 1, 0);
    chk("R4 fifteen errored", reg_rdata, 16'hFF8E);
    op(1, 8'h4F, 1, 1, 0);
    chk("R4 sixteen errored wraps", reg_rdata, 16'h008E);
    op(1, 8'hEE, 0, 0, 0);
    chk("R5 push on full dropped", reg_rdata, 16'h008E);
    op(1, 8'hEF, 0, 0, 1);
    chk("R5 push with pop on full", reg_rdata, 16'hFF8E);
    for (int i = 0; i < 15; i++) op(0, 8'h00, 0, 0, 1);
    chk("R5 drained after full", reg_rdata, 16'h0082);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule